// File: doc/BRIEF.md
# Pipelined Constant-Coefficient LUT Multiplier

This block multiplies an 8-bit unsigned operand by a fixed coefficient without a multiplier array. Each nibble of the operand indexes its own 16-entry table of 12-bit precomputed products. The lower nibble uses the low table and the upper nibble uses the high table. The high table's output is weighted by 16, so it is shifted four places left. The two table outputs are then summed in a chain of 4-bit adder slices, with a register on the carry between neighbouring slices. Skew registers line up the operand nibbles and the result nibbles so that a new operand can enter on every clock. Each operand yields a 16-bit product a fixed three cycles later.

The coefficient is not a port. After reset both tables hold `n * COEF`. A host changes the coefficient by rewriting table entries through a single-entry write port. A separate hold input lets the host mark a multi-cycle reload as in progress. Any operand sampled while the hold input or a write is active produces a result with its valid flag low. The product is still computed from whatever the tables contain, and the flag tells the consumer to discard it.

Top module: `cmul_lut`

## Requirements
- R1: While rst_ni is low, vld_o is 0 and prod_o is 0. Reset restores every entry n of both tables to n * COEF, which undoes earlier writes.
- R2: After reset with no writes, prod_o equals data_i * COEF for any 8-bit data_i. COEF defaults to 3.
- R3: One operand is accepted on every clock. Back-to-back operands produce back-to-back results in the same order.
- R4: For arbitrary table contents, prod_o = low_table[data_i[3:0]] + 16 * high_table[data_i[7:4]].
- R5: Carries propagate through all four result slices. With every entry n set to n * 255, the operand 255 gives 65025 (0xFE01).
- R6: At a rising edge where wr_en_i is 1, table entry wr_addr_i takes the value wr_data_i. wr_sel_i = 0 selects the low table, indexed by data_i[3:0]. wr_sel_i = 1 selects the high table, indexed by data_i[7:4]. All other entries keep their values.
- R7: vld_o and prod_o for an operand sampled at rising edge k are updated at edge k+3. vld_o repeats vld_i, so an operand sampled with vld_i = 0 yields vld_o = 0.
- R8: An operand sampled while hold_i = 1 or wr_en_i = 1 yields vld_o = 0, whatever vld_i is.
- R9: Writing n * K into entry n of both tables makes later products equal data_i * K.
- R10: The sum is taken modulo 2^16. If entry 15 of both tables is 0xFFF, the operand 0xFF gives 0x0FEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operand valid |
| data_i | input | 8 | Unsigned operand |
| hold_i | input | 1 | Reload in progress; results are marked invalid |
| wr_en_i | input | 1 | Table entry write strobe |
| wr_sel_i | input | 1 | Table select: 0 low table, 1 high table |
| wr_addr_i | input | 4 | Table entry index |
| wr_data_i | input | 12 | New table entry value |
| vld_o | output | 1 | Result valid |
| prod_o | output | 16 | Product |

## Verification
Every result, valid or not, is due at the third rising edge after the edge that samples its operand. Table writes take effect at the edge of the write, so an operand sampled at that same edge still reads the old entry.

The bench drives inputs on the falling edge. It keeps a four-slot queue of expected results and compares the slot from three steps earlier on the falling edge that follows the third edge. Expected values come from bench-side copies of both tables, updated whenever the bench issues a write. The valid flag is checked on every step, and the product only when a valid result is expected.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic {
    TBL_LO = 1'b0,
    TBL_HI = 1'b1
  } tbl_sel_e;

  function automatic logic [31:0] init_entry(input int unsigned idx, input int unsigned coef);
    return 32'(idx * coef);
  endfunction
endpackage

// File: rtl/nib_add.sv
module nib_add #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] s_o,
  output logic         co_o
);
  timeunit 1ns;
  timeprecision 1ps;

  assign {co_o, s_o} = {1'b0, a_i} + {1'b0, b_i} + (W+1)'(ci_i);
endmodule

// File: rtl/nib_table.sv
module nib_table
  import cmul_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned COEF   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(init_entry(i, COEF));
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  assert_entry_written_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_addr_i)] == $past(wr_data_i));
endmodule

// File: rtl/cmul_lut.sv
module cmul_lut
  import cmul_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned ENT_W = 12,
  parameter int unsigned COEF  = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   vld_i,
  input  logic [2*NIB_W-1:0]     data_i,
  input  logic                   hold_i,
  input  logic                   wr_en_i,
  input  logic                   wr_sel_i,
  input  logic [NIB_W-1:0]       wr_addr_i,
  input  logic [ENT_W-1:0]       wr_data_i,
  output logic                   vld_o,
  output logic [ENT_W+NIB_W-1:0] prod_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned PROD_W = ENT_W + NIB_W;
  localparam int unsigned NA     = ENT_W / NIB_W;  // nibbles per table entry
  localparam int unsigned NS     = PROD_W / NIB_W; // adder slices = pipeline depth

  logic                lo_we, hi_we, clean_d;
  logic [ENT_W-1:0]    rd_lo, rd_hi;
  logic [NS-1:0]       cy_bus;
  logic [PROD_W-1:0]   res_bus;
  logic                v_q [NS];

  assign lo_we   = wr_en_i && (tbl_sel_e'(wr_sel_i) == TBL_LO);
  assign hi_we   = wr_en_i && (tbl_sel_e'(wr_sel_i) == TBL_HI);
  assign clean_d = vld_i && !hold_i && !wr_en_i;

  nib_table #(.ADDR_W(NIB_W), .DATA_W(ENT_W), .COEF(COEF)) u_tbl_lo (
    .clk_i, .rst_ni, .wr_en_i(lo_we), .wr_addr_i, .wr_data_i,
    .rd_addr_i(data_i[NIB_W-1:0]), .rd_data_o(rd_lo)
  );

  nib_table #(.ADDR_W(NIB_W), .DATA_W(ENT_W), .COEF(COEF)) u_tbl_hi (
    .clk_i, .rst_ni, .wr_en_i(hi_we), .wr_addr_i, .wr_data_i,
    .rd_addr_i(data_i[2*NIB_W-1:NIB_W]), .rd_data_o(rd_hi)
  );

  assign cy_bus[0] = 1'b0;

  // Slice j adds low-table nibble j and high-table nibble j-1 (the 4-bit offset).
  for (genvar j = 0; j < NS; j++) begin : g_nib
    localparam int unsigned POST = NS - 1 - j;
    logic [NIB_W-1:0] a_src, b_src, a_use, b_use, sum_d;
    logic [NIB_W-1:0] r_q [POST+1];

    if (j < NA) begin : g_a
      assign a_src = rd_lo[j*NIB_W +: NIB_W];
    end else begin : g_a0
      assign a_src = '0;
    end

    if (j > 0) begin : g_b
      assign b_src = rd_hi[(j-1)*NIB_W +: NIB_W];
    end else begin : g_b0
      assign b_src = '0;
    end

    // Operand skew: slice j works j cycles after the table lookup.
    if (j == 0) begin : g_nopre
      assign a_use = a_src;
      assign b_use = b_src;
    end else begin : g_pre
      logic [NIB_W-1:0] a_q [j];
      logic [NIB_W-1:0] b_q [j];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int k = 0; k < j; k++) begin
            a_q[k] <= '0;
            b_q[k] <= '0;
          end
        end else begin
          a_q[0] <= a_src;
          b_q[0] <= b_src;
          for (int k = 1; k < j; k++) begin
            a_q[k] <= a_q[k-1];
            b_q[k] <= b_q[k-1];
          end
        end
      end
      assign a_use = a_q[j-1];
      assign b_use = b_q[j-1];
    end

    if (j < NS - 1) begin : g_carry
      logic co, cy_q;
      nib_add #(.W(NIB_W)) u_add (
        .a_i(a_use), .b_i(b_use), .ci_i(cy_bus[j]), .s_o(sum_d), .co_o(co)
      );
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cy_q <= 1'b0;
        else         cy_q <= co;
      end
      assign cy_bus[j+1] = cy_q;
    end else begin : g_top
      // Top slice: carry out falls off the 16-bit result.
      assign sum_d = a_use + b_use + NIB_W'(cy_bus[j]);
    end

    // Result deskew: all nibbles leave together.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k <= POST; k++) r_q[k] <= '0;
      end else begin
        r_q[0] <= sum_d;
        for (int k = 1; k <= POST; k++) r_q[k] <= r_q[k-1];
      end
    end

    assign res_bus[j*NIB_W +: NIB_W] = r_q[POST];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NS; k++) v_q[k] <= 1'b0;
    end else begin
      v_q[0] <= clean_d;
      for (int k = 1; k < NS; k++) v_q[k] <= v_q[k-1];
    end
  end

  assign vld_o  = v_q[NS-1];
  assign prod_o = res_bus;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_rst_clear_R1: assert (!vld_o && prod_o == '0);
    end
  end

  if (NS == 4) begin : g_chk
    assert_vld_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && !hold_i && !wr_en_i) |-> ##4 vld_o);
    assert_no_vld_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vld_i |-> ##4 !vld_o);
    assert_reload_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_i || wr_en_i) |-> ##4 !vld_o);
  end
endmodule

// File: tb/cmul_lut_tb_top.sv
module cmul_lut_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int COEF = 3;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        vld_i, hold_i, wr_en_i, wr_sel_i;
  logic [7:0]  data_i;
  logic [3:0]  wr_addr_i;
  logic [11:0] wr_data_i;
  logic        vld_o;
  logic [15:0] prod_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int          ref_lo [16];
  int          ref_hi [16];
  logic        hv [4];
  logic [15:0] hp [4];
  bit          hc [4];
  string       ht [4];

  cmul_lut dut_i (
    .clk_i(clk), .rst_ni, .vld_i, .data_i, .hold_i, .wr_en_i, .wr_sel_i,
    .wr_addr_i, .wr_data_i, .vld_o, .prod_o
  );

  always #2.5 clk = ~clk;

  task automatic clear_hist();
    for (int i = 0; i < 4; i++) begin
      hv[i] = 1'b0; hp[i] = '0; hc[i] = 1'b0; ht[i] = "";
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic h, input logic we,
                      input logic ws, input logic [3:0] wa, input logic [11:0] wd,
                      input string tag);
    vld_i = v; data_i = d; hold_i = h; wr_en_i = we;
    wr_sel_i = ws; wr_addr_i = wa; wr_data_i = wd;
    for (int i = 3; i > 0; i--) begin
      hv[i] = hv[i-1]; hp[i] = hp[i-1]; hc[i] = hc[i-1]; ht[i] = ht[i-1];
    end
    hv[0] = v && !h && !we;
    hp[0] = 16'(ref_lo[d[3:0]] + (ref_hi[d[7:4]] << 4));
    hc[0] = 1'b1;
    ht[0] = tag;
    if (we) begin
      if (ws) ref_hi[wa] = int'(wd);
      else    ref_lo[wa] = int'(wd);
    end
    @(posedge clk);
    @(negedge clk);
    if (hc[3]) begin
      checks++;
      if (vld_o !== hv[3] || (hv[3] && prod_o !== hp[3])) begin
        errors++;
        $display("FAIL %s: vld_o=%0b prod_o=0x%h expected vld_o=%0b prod_o=0x%h",
                 ht[3], vld_o, prod_o, hv[3], hp[3]);
      end
    end
  endtask

  task automatic feed(input logic [7:0] d, input string tag);
    step(1'b1, d, 1'b0, 1'b0, 1'b0, 4'h0, 12'h0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 12'h0, tag);
  endtask

  task automatic wr(input logic sel, input logic [3:0] a, input logic [11:0] d, input string tag);
    step(1'b0, 8'h00, 1'b0, 1'b1, sel, a, d, tag);
  endtask

  task automatic drain(input string tag);
    repeat (4) idle(tag);
  endtask

  task automatic check_reset_outputs(input string tag);
    checks++;
    if (vld_o !== 1'b0 || prod_o !== 16'h0) begin
      errors++;
      $display("FAIL %s: vld_o=%0b prod_o=0x%h expected vld_o=0 prod_o=0x0000", tag, vld_o, prod_o);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    vld_i = 0; data_i = 0; hold_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_addr_i = 0; wr_data_i = 0;
    for (int i = 0; i < 16; i++) begin
      ref_lo[i] = i * COEF;
      ref_hi[i] = i * COEF;
    end
    clear_hist();
    @(negedge clk);
    @(negedge clk);
    check_reset_outputs("R1");
    rst_ni = 1'b1;
  endtask

  // R1: outputs cleared in reset, and reset undoes table writes
  task automatic test_reset();
    wr(1'b0, 4'h5, 12'h777, "R1");
    feed(8'h05, "R1");
    do_reset();
    feed(8'h05, "R1");
    feed(8'h50, "R1");
    drain("R1");
  endtask

  // R2 R3: default coefficient, back-to-back stream
  task automatic test_default();
    logic [7:0] vals [8] = '{8'h00, 8'h01, 8'h07, 8'h10, 8'h5A, 8'hA5, 8'hF0, 8'hFF};
    for (int i = 0; i < 8; i++) feed(vals[i], "R2 R3");
    drain("R3");
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (16'(ref_lo[vals[i][3:0]] + (ref_hi[vals[i][7:4]] << 4)) !== 16'(int'(vals[i]) * COEF)) begin
        errors++;
        $display("FAIL R2: model 0x%h expected 0x%h", 16'(ref_lo[vals[i][3:0]] + (ref_hi[vals[i][7:4]] << 4)),
                 16'(int'(vals[i]) * COEF));
      end
    end
  endtask

  // R7: valid flag follows vld_i with gaps
  task automatic test_valid_gap();
    feed(8'h11, "R7");
    idle("R7");
    feed(8'h22, "R7");
    step(1'b0, 8'h33, 1'b0, 1'b0, 1'b0, 4'h0, 12'h0, "R7");
    feed(8'h44, "R7");
    drain("R7");
  endtask

  // R4 R6: arbitrary table contents, write lands only in the selected entry
  task automatic test_table_write();
    wr(1'b0, 4'h3, 12'hABC, "R6");
    wr(1'b1, 4'h3, 12'h123, "R6");
    wr(1'b1, 4'hC, 12'h0F0, "R6");
    feed(8'h33, "R4 R6");
    feed(8'hC3, "R4 R6");
    feed(8'h34, "R4 R6");
    feed(8'h23, "R4 R6");
    feed(8'hC0, "R4 R6");
    drain("R4");
  endtask

  // R8: hold and write mark results invalid
  task automatic test_hold();
    step(1'b1, 8'h12, 1'b1, 1'b0, 1'b0, 4'h0, 12'h0, "R8");
    step(1'b1, 8'h34, 1'b1, 1'b0, 1'b0, 4'h0, 12'h0, "R8");
    step(1'b1, 8'h56, 1'b0, 1'b1, 1'b0, 4'h9, 12'(9 * COEF), "R8");
    feed(8'h78, "R8");
    drain("R8");
  endtask

  // R9 R5: reload to coefficient 255, full carry ripple
  task automatic test_reload();
    for (int i = 0; i < 16; i++) wr(1'b0, 4'(i), 12'(i * 255), "R9");
    for (int i = 0; i < 16; i++) wr(1'b1, 4'(i), 12'(i * 255), "R9");
    feed(8'hFF, "R5 R9");
    feed(8'h80, "R9");
    feed(8'h0F, "R5");
    feed(8'hF1, "R5");
    drain("R9");
    checks++;
    if (16'(ref_lo[15] + (ref_hi[15] << 4)) !== 16'hFE01) begin
      errors++;
      $display("FAIL R5: model 0x%h expected 0xfe01", 16'(ref_lo[15] + (ref_hi[15] << 4)));
    end
  endtask

  // R10: modulo 2^16 wrap
  task automatic test_wrap();
    wr(1'b0, 4'hF, 12'hFFF, "R10");
    wr(1'b1, 4'hF, 12'hFFF, "R10");
    feed(8'hFF, "R10");
    drain("R10");
    checks++;
    if (16'(ref_lo[15] + (ref_hi[15] << 4)) !== 16'h0FEF) begin
      errors++;
      $display("FAIL R10: model 0x%h expected 0x0fef", 16'(ref_lo[15] + (ref_hi[15] << 4)));
    end
  endtask

  initial begin
    rst_ni = 1'b1;
    clear_hist();
    #1;
    do_reset();
    test_default();
    test_valid_gap();
    test_table_write();
    test_hold();
    test_reload();
    test_wrap();
    test_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule